// File: doc/BRIEF.md
# Single-Lane Flash Command Sequencer

This block issues one short serial-flash command at a time. A host fills four registers over a simple write port: a packed command word, an address word and two staging words for outgoing data. Writing the command word with its execute bit set launches a frame on a single-bit serial interface. Each frame is an opcode, an optional address of one to four bytes, an optional run of dummy clocks, and then either one to eight bytes of outgoing data or one to eight bytes of incoming data. Bytes returned by the flash are collected into two 32-bit result words.

The serial side is a one-bit shifter interface: one bit per clock cycle, with a select request and a clock enable that are both high for every bit of the frame. A busy flag, which stands for the in-progress bit of the command word, stays high for as long as the frame lasts. While it is high, every register write is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `cmd_busy`, `spi_sel` and `spi_sclk_en` are 0, and `rdata_lo` and `rdata_hi` are 0.
- R2: The register written is chosen by `bus_sel`: 0 is the command word, 1 the address word, 2 the low data word and 3 the high data word. A command-word write with bit 0 (execute) set, made while idle, starts a frame. From the next cycle, `cmd_busy`, `spi_sel` and `spi_sclk_en` are 1 for exactly N cycles, with N = 8 + 8·A + D + 8·L. A, D and L are the address, dummy and data lengths in use. All three signals then return to 0.
- R3: The first 8 frame bits are the opcode, command bits 31:24, most significant bit first.
- R4: When command bit 19 is set, A = (bits 17:16) + 1 address bytes follow the opcode. They are the low 8·A bits of the address word, sent most significant bit first.
- R5: Command bits 11:7 give D, the number of dummy clocks (0 to 31). They follow the address, and `spi_mosi` is 0 during them.
- R6: When command bit 15 is set, L = (bits 14:12) + 1 data bytes are sent last. Byte k sits in bits 8k+7:8k of the 64-bit value {high word, low word}, so byte 0 is low-word bits 7:0. Bytes go in order 0, 1, … and each byte goes most significant bit first.
- R7: When command bit 23 is set, L = (bits 22:20) + 1 bytes are read last, with `spi_mosi` 0. `spi_miso` is sampled at the clock edge that ends each read bit. The n-th bit received lands at bit 8·(n div 8) + 7 − (n mod 8) of {`rdata_hi`, `rdata_lo`}. Every started frame clears both result words to 0, and the final values are present when `cmd_busy` falls.
- R8: When bits 23 and 15 are both set, only the outgoing data phase runs. No read phase occurs and the result words stay 0.
- R9: Any register write made while `cmd_busy` is 1 is ignored. This covers data, address and command words, and an execute as well. Frames already running and frames started later are not affected by it.
- R10: A command-word write with bit 0 clear stores the word but does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select (0 command, 1 address, 2 data low, 3 data high) |
| bus_wdata | input | 32 | Register write data |
| cmd_busy | output | 1 | Frame in progress |
| rdata_lo | output | 32 | Received bytes 0 to 3 |
| rdata_hi | output | 32 | Received bytes 4 to 7 |
| spi_sel | output | 1 | Select request, high for the whole frame |
| spi_sclk_en | output | 1 | Serial clock enable, high for each frame bit |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A command write is taken at clock edge E. Frame bit k appears on `spi_mosi` in the cycle after edge E+k, and `cmd_busy`, `spi_sel` and `spi_sclk_en` rise one cycle after E. A read bit is taken from `spi_miso` at the edge that ends its cycle. The result words therefore reach their final value at edge E+N, the same edge at which the busy flag falls. The bench holds a queue of expected frame bits built when it sees the accepted write at E. It pops one entry per edge and compares outputs at the falling edge midway between edges, so every comparison sees values that settled one half-cycle earlier.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BUS_W      = 32;
  localparam int ADDR_BYTES = 4;
  localparam int DATA_BYTES = 8;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int POS_W      = $clog2(DATA_W);

  // command word field positions (the host encodes frames this way)
  localparam int OPC_LSB    = 24;
  localparam int RD_EN_BIT  = 23;
  localparam int RD_CNT_LSB = 20;
  localparam int AD_EN_BIT  = 19;
  localparam int AD_CNT_LSB = 16;
  localparam int WR_EN_BIT  = 15;
  localparam int WR_CNT_LSB = 12;
  localparam int DMY_LSB    = 7;
  localparam int EXEC_BIT   = 0;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_WLO  = 2'd2;
  localparam logic [1:0] SEL_WHI  = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_DUMMY, PH_WDATA, PH_RDATA
  } phase_t;

  typedef struct packed {
    logic       rd_en;
    logic [2:0] rd_cnt;
    logic       ad_en;
    logic [1:0] ad_cnt;
    logic       wr_en;
    logic [2:0] wr_cnt;
    logic [4:0] dummy;
  } shape_t;

  typedef struct packed {
    logic [7:0] opcode;
    shape_t     shape;
  } cmd_t;
endpackage

// File: rtl/fcs_regfile.sv
module fcs_regfile
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              busy,
  output cmd_t              ctrl_cmd,
  output cmd_t              new_cmd,
  output logic              start,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdat_q
);
  logic accept;

  assign accept = bus_wr && !busy;
  assign start  = accept && (bus_sel == SEL_CMD) && bus_wdata[EXEC_BIT];

  always_comb begin
    new_cmd.opcode       = bus_wdata[OPC_LSB +: 8];
    new_cmd.shape.rd_en  = bus_wdata[RD_EN_BIT];
    new_cmd.shape.rd_cnt = bus_wdata[RD_CNT_LSB +: 3];
    new_cmd.shape.ad_en  = bus_wdata[AD_EN_BIT];
    new_cmd.shape.ad_cnt = bus_wdata[AD_CNT_LSB +: 2];
    new_cmd.shape.wr_en  = bus_wdata[WR_EN_BIT];
    new_cmd.shape.wr_cnt = bus_wdata[WR_CNT_LSB +: 3];
    new_cmd.shape.dummy  = bus_wdata[DMY_LSB +: 5];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_cmd <= '0;
      addr_q   <= '0;
      wdat_q   <= '0;
    end else if (accept) begin
      case (bus_sel)
        SEL_CMD:  ctrl_cmd <= new_cmd;
        SEL_ADDR: addr_q   <= bus_wdata[ADDR_W-1:0];
        SEL_WLO:  wdat_q[BUS_W-1:0] <= bus_wdata;
        default:  wdat_q[DATA_W-1:BUS_W] <= bus_wdata;
      endcase
    end
  end

  // R9: nothing held here moves after a write that arrived while busy
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr) |=> ($stable(addr_q) && $stable(wdat_q) && $stable(ctrl_cmd)));
endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  shape_t           shape,
  input  logic             tx_bit,
  output phase_t           phase_q,
  output logic [POS_W-1:0] pos_q,
  output phase_t           nxt_phase,
  output logic [POS_W-1:0] nxt_pos,
  output logic             busy_o,
  output logic             sel_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  function automatic int phase_len(phase_t p, shape_t s);
    case (p)
      PH_OPC:   return 8;
      PH_ADDR:  return 8 * (int'(s.ad_cnt) + 1);
      PH_DUMMY: return int'(s.dummy);
      PH_WDATA: return 8 * (int'(s.wr_cnt) + 1);
      PH_RDATA: return 8 * (int'(s.rd_cnt) + 1);
      default:  return 0;
    endcase
  endfunction

  // next non-empty phase in the fixed frame order; write beats read
  function automatic phase_t after(phase_t p, shape_t s);
    if (p == PH_OPC && s.ad_en) return PH_ADDR;
    if ((p == PH_OPC || p == PH_ADDR) && s.dummy != 5'd0) return PH_DUMMY;
    if (p != PH_WDATA && p != PH_RDATA && s.wr_en) return PH_WDATA;
    if (p != PH_WDATA && p != PH_RDATA && s.rd_en) return PH_RDATA;
    return PH_IDLE;
  endfunction

  logic last;
  assign last = (int'(pos_q) == phase_len(phase_q, shape) - 1);

  always_comb begin
    nxt_phase = phase_q;
    nxt_pos   = pos_q;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        nxt_phase = PH_OPC;
        nxt_pos   = '0;
      end
    end else if (!last) begin
      nxt_pos = pos_q + 1'b1;
    end else begin
      nxt_phase = after(phase_q, shape);
      nxt_pos   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pos_q   <= '0;
      busy_o  <= 1'b0;
      sel_o   <= 1'b0;
      sclk_o  <= 1'b0;
      mosi_o  <= 1'b0;
    end else begin
      phase_q <= nxt_phase;
      pos_q   <= nxt_pos;
      busy_o  <= (nxt_phase != PH_IDLE);
      sel_o   <= (nxt_phase != PH_IDLE);
      sclk_o  <= (nxt_phase != PH_IDLE);
      mosi_o  <= tx_bit;
    end
  end

  // R2: an accepted execute raises busy at the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_o);
  // R8: a read phase never runs for a command that also writes
  p_no_read_on_write_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RDATA) |-> !shape.wr_en);
endmodule

// File: rtl/fcs_tx_bit.sv
module fcs_tx_bit
  import fcs_pkg::*;
(
  input  phase_t            phase,
  input  logic [POS_W-1:0]  pos,
  input  logic [7:0]        opcode,
  input  logic [1:0]        ad_cnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdat,
  output logic              bit_o
);
  logic [4:0] aidx;

  assign aidx = {ad_cnt, 3'b111} - pos[4:0];

  always_comb begin
    case (phase)
      PH_OPC:   bit_o = opcode[~pos[2:0]];
      PH_ADDR:  bit_o = addr[aidx];
      PH_WDATA: bit_o = wdat[{pos[POS_W-1:3], ~pos[2:0]}];
      default:  bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcs_rx_capture.sv
module fcs_rx_capture
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  phase_t            phase,
  input  logic [POS_W-1:0]  pos,
  input  logic              miso,
  output logic [DATA_W-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst || start) begin
      rd_q <= '0;
    end else if (phase == PH_RDATA) begin
      rd_q[{pos[POS_W-1:3], ~pos[2:0]}] <= miso;
    end
  end

  // R7: result words only move while a read phase runs or a frame starts
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_RDATA && !start) |=> $stable(rd_q));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              cmd_busy,
  output logic [BUS_W-1:0]  rdata_lo,
  output logic [BUS_W-1:0]  rdata_hi,
  output logic              spi_sel,
  output logic              spi_sclk_en,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  cmd_t              ctrl_cmd, new_cmd, cmd_eff;
  logic              start, tx_bit;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rd_q;
  phase_t            phase_q, nxt_phase;
  logic [POS_W-1:0]  pos_q, nxt_pos;

  fcs_regfile u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .busy(cmd_busy), .ctrl_cmd(ctrl_cmd),
    .new_cmd(new_cmd), .start(start), .addr_q(addr_q), .wdat_q(wdat_q)
  );

  // the word being written drives the first bit; the stored word after that
  assign cmd_eff = start ? new_cmd : ctrl_cmd;

  fcs_sequencer u_seq (
    .clk(clk), .rst(rst), .start(start), .shape(cmd_eff.shape),
    .tx_bit(tx_bit), .phase_q(phase_q), .pos_q(pos_q),
    .nxt_phase(nxt_phase), .nxt_pos(nxt_pos), .busy_o(cmd_busy),
    .sel_o(spi_sel), .sclk_o(spi_sclk_en), .mosi_o(spi_mosi)
  );

  fcs_tx_bit u_tx (
    .phase(nxt_phase), .pos(nxt_pos), .opcode(cmd_eff.opcode),
    .ad_cnt(cmd_eff.shape.ad_cnt), .addr(addr_q), .wdat(wdat_q),
    .bit_o(tx_bit)
  );

  fcs_rx_capture u_rx (
    .clk(clk), .rst(rst), .start(start), .phase(phase_q), .pos(pos_q),
    .miso(spi_miso), .rd_q(rd_q)
  );

  assign rdata_lo = rd_q[BUS_W-1:0];
  assign rdata_hi = rd_q[DATA_W-1:BUS_W];

  // R5: dummy clocks carry a low data line
  p_dummy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DUMMY) |-> !spi_mosi);
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic        cmd_busy, spi_sel, spi_sclk_en, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [31:0] rdata_lo, rdata_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .cmd_busy(cmd_busy), .rdata_lo(rdata_lo),
    .rdata_hi(rdata_hi), .spi_sel(spi_sel), .spi_sclk_en(spi_sclk_en),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mq[$];   // expected mosi per frame bit
  bit          rq[$];   // bit is a read bit
  int          tq[$];   // requirement each bit belongs to
  logic [31:0] m_addr, m_lo, m_hi;
  logic [63:0] exp_rd;
  int          rcount;
  bit          was_busy;

  task automatic build(input logic [31:0] w);
    int a, d, l;
    logic [63:0] wb;
    exp_rd = '0;
    rcount = 0;
    for (int i = 7; i >= 0; i--) begin mq.push_back(w[24+i]); rq.push_back(0); tq.push_back(3); end // R3
    if (w[19]) begin // R4
      a = int'(w[17:16]) + 1;
      for (int i = 8*a-1; i >= 0; i--) begin mq.push_back(m_addr[i]); rq.push_back(0); tq.push_back(4); end
    end
    d = int'(w[11:7]); // R5
    for (int i = 0; i < d; i++) begin mq.push_back(0); rq.push_back(0); tq.push_back(5); end
    wb = {m_hi, m_lo};
    if (w[15]) begin // R6, also R8 when both set
      l = int'(w[14:12]) + 1;
      for (int b = 0; b < l; b++)
        for (int i = 7; i >= 0; i--) begin mq.push_back(wb[8*b+i]); rq.push_back(0); tq.push_back(6); end
    end else if (w[23]) begin // R7
      l = int'(w[22:20]) + 1;
      for (int i = 0; i < 8*l; i++) begin mq.push_back(0); rq.push_back(1); tq.push_back(7); end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); rq.delete(); tq.delete();
      m_addr = '0; m_lo = '0; m_hi = '0; exp_rd = '0; rcount = 0;
    end else begin
      was_busy = (mq.size() > 0);
      if (was_busy) begin
        if (rq[0]) begin
          exp_rd[(rcount/8)*8 + 7 - (rcount%8)] = spi_miso;
          rcount++;
        end
        void'(mq.pop_front()); void'(rq.pop_front()); void'(tq.pop_front());
      end
      if (bus_wr && !was_busy) begin // R9: writes while busy dropped
        case (bus_sel)
          2'd0: if (bus_wdata[0]) build(bus_wdata); // R10: no execute, no frame
          2'd1: m_addr = bus_wdata;
          2'd2: m_lo = bus_wdata;
          default: m_hi = bus_wdata;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison at the falling edge ----------------
  bit          chk_on = 0;
  bit          exp_busy;
  int          run = 0;
  int          last_run = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (!rst && chk_on) begin
      exp_busy = (mq.size() > 0);
      chk(cmd_busy === exp_busy, 2, "busy", 64'(cmd_busy), 64'(exp_busy));       // R2
      chk(spi_sel === exp_busy, 2, "select", 64'(spi_sel), 64'(exp_busy));
      chk(spi_sclk_en === exp_busy, 2, "clock enable", 64'(spi_sclk_en), 64'(exp_busy));
      if (exp_busy) chk(spi_mosi === mq[0], tq[0], "mosi bit", 64'(spi_mosi), 64'(mq[0]));
      chk({rdata_hi, rdata_lo} === exp_rd, 7, "read data", {rdata_hi, rdata_lo}, exp_rd); // R7
      if (cmd_busy) run++;
      else if (run != 0) begin last_run = run; run = 0; end
    end
    spi_miso = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle(input int n, input int req);
    while (cmd_busy) @(negedge clk);
    @(posedge clk);
    chk(last_run == n, req, "frame length", 64'(last_run), 64'(n));
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit re, input int rn,
                                     input bit ae, input int an, input bit we, input int wn,
                                     input int dm, input bit ex);
    logic [31:0] w = '0;
    w[31:24] = op;
    w[23] = re; w[22:20] = 3'(rn - 1);
    w[19] = ae; w[17:16] = 2'(an - 1);
    w[15] = we; w[14:12] = 3'(wn - 1);
    w[11:7] = 5'(dm);
    w[0] = ex;
    return w;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cmd_busy === 1'b0, 1, "busy after reset", 64'(cmd_busy), 0);
    chk(spi_sel === 1'b0 && spi_sclk_en === 1'b0, 1, "select after reset", 64'({spi_sel, spi_sclk_en}), 0);
    chk({rdata_hi, rdata_lo} === 64'd0, 1, "read data after reset", {rdata_hi, rdata_lo}, 0);

    // R3 R7: opcode then 3 read bytes
    bus_write(2'd0, mk(8'h9F, 1, 3, 0, 1, 0, 1, 0, 1));
    wait_idle(32, 7);

    // R4 R6: 3-byte address then 2 write bytes
    bus_write(2'd1, 32'hA1B2C3D4);
    bus_write(2'd2, 32'h0000_5AC3);
    bus_write(2'd0, mk(8'h02, 0, 1, 1, 3, 1, 2, 0, 1));
    wait_idle(48, 4);

    // R4 R5 R7: 4-byte address, 8 dummy clocks, 8 read bytes
    bus_write(2'd1, 32'h8C4E2F71);
    bus_write(2'd0, mk(8'h0B, 1, 8, 1, 4, 0, 1, 8, 1));
    wait_idle(112, 7);

    // R6: 8 write bytes across both data words
    bus_write(2'd2, 32'h89ABCDEF);
    bus_write(2'd3, 32'h01234567);
    bus_write(2'd0, mk(8'h32, 0, 1, 0, 1, 1, 8, 0, 1));
    wait_idle(72, 6);

    // R8: read and write both enabled, write wins
    bus_write(2'd0, mk(8'h5A, 1, 4, 0, 1, 1, 1, 0, 1));
    wait_idle(16, 8);
    chk({rdata_hi, rdata_lo} === 64'd0, 8, "no read phase", {rdata_hi, rdata_lo}, 0);

    // R10: command word without execute
    bus_write(2'd0, mk(8'hC7, 0, 1, 0, 1, 0, 1, 0, 0));
    chk(cmd_busy === 1'b0, 10, "no start without execute", 64'(cmd_busy), 0);
    @(negedge clk);
    chk(spi_sel === 1'b0, 10, "select stays low", 64'(spi_sel), 0);

    // R9: writes during a frame are dropped
    bus_write(2'd2, 32'h11223344);
    bus_write(2'd0, mk(8'h02, 0, 1, 0, 1, 1, 4, 0, 1));
    bus_write(2'd2, 32'hDEADBEEF);
    bus_write(2'd0, mk(8'hFF, 1, 8, 1, 4, 0, 1, 31, 1));
    bus_write(2'd1, 32'hFFFFFFFF);
    wait_idle(40, 9);
    bus_write(2'd0, mk(8'h02, 0, 1, 1, 3, 1, 4, 0, 1));
    wait_idle(64, 9);

    // R4 R5: 1-byte address plus 3 dummy clocks, then longest dummy run
    bus_write(2'd0, mk(8'hA5, 0, 1, 1, 1, 0, 1, 3, 1));
    wait_idle(19, 5);
    bus_write(2'd0, mk(8'h3C, 0, 1, 0, 1, 0, 1, 31, 1));
    wait_idle(39, 5);

    // R7: single read byte after dummy clocks
    bus_write(2'd0, mk(8'h05, 1, 1, 0, 1, 0, 1, 2, 1));
    wait_idle(18, 7);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule